// File: doc/BRIEF.md
# Fractional Bit-Rate Tick Generator

This block derives bit timing for an asynchronous serial port from one fast clock. The fast clock need not be an integer multiple of the bit rate. An integer prescaler sets the base length of a period. Two modulation stages then add single clocks to some periods, so that the long-run average period matches a fractional ratio.

In oversampling mode a bit is split into sixteen sample periods. A small first-stage value chooses how many of those sixteen periods get one extra clock, and the extra clocks are spread evenly across the bit. In both modes an 8-bit second-stage pattern adds one more clock to whole bit periods, one pattern bit per bit period, cycling through the pattern.

A configuration hold input keeps all timing state cleared while software writes the settings. Timing starts again from the beginning of a bit once the hold is released.

Top module: `frac_baud_gen`

## Requirements
- R1: With oversampling off, each bit period lasts P + b input clocks. P is the prescaler value and b is the current pattern bit.
- R2: The pattern is consumed one bit per bit period, starting at bit 0 and moving up to bit 7, then wrapping back to bit 0.
- R3: With oversampling on, every bit period holds exactly sixteen sample ticks, each with a base length of P clocks. The bit tick is asserted in the same cycle as the sixteenth sample tick.
- R4: With oversampling on and first-stage value f, sample period j (0 to 15) is one clock longer when floor((j+1)·f/16) is greater than floor(j·f/16). A bit therefore lasts 16·P + f + b clocks.
- R5: With oversampling on, the pattern bit lengthens only the sixteenth sample period of the bit.
- R6: A prescaler value of 0 behaves as a value of 1.
- R7: While the hold input is high, no tick is produced, and the counters, the sub-sample accumulator and the pattern index are cleared. After release, timing begins a fresh bit that uses pattern bit 0.
- R8: With oversampling off, the sample tick stays low.
- R9: Ticks are single-cycle pulses. Over 256 bit periods the total clock count equals 256 times the base bit length, plus f·256 in oversampling mode, plus 32 times the number of ones in the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | 1 | Holds timing cleared while settings change |
| cfg_os_en | input | 1 | Enables sixteen-times oversampling |
| cfg_prescale | input | 16 | Integer prescaler; 0 is treated as 1 |
| cfg_frac1 | input | 4 | First-stage count of stretched sample periods per bit |
| cfg_frac2 | input | 8 | Second-stage per-bit stretch pattern, bit 0 first |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |
| sample_tick | output | 1 | One-cycle pulse at the end of each sample period (oversampling only) |

## Verification
The hardest case to reach from the ports is the hold being released partway through a bit, with the sub-sample accumulator and the pattern index at arbitrary non-zero values. Every configuration is therefore run briefly, frozen mid-bit with the hold, and released. The first measured bit must then use pattern bit 0 and the sample spreading from index 0. Each run then times every bit and every sample period over 256 bits against arithmetic predictions. The runs cover prescaler 0, small prescalers, empty and full patterns, and first-stage values 0, 5, 8 and 15, so both the plain and the spread stretching are exercised.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
   // Effective prescaler: a zero setting counts as one clock.
   function automatic logic [15:0] eff_div(input logic [15:0] v);
      return (v == '0) ? 16'd1 : v;
   endfunction

   typedef struct packed {
      logic bit_end;
      logic smp_end;
   } tick_t;
endpackage

// File: rtl/fbg_spread.sv
module fbg_spread #(
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [FRAC_W-1:0] frac,
   input  logic              period_end,
   output logic              stretch,
   output logic              last_smp
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W-1:0] smp_q;
   logic [FRAC_W:0]   sum;

   assign sum      = {1'b0, acc_q} + {1'b0, frac};
   assign stretch  = en & sum[FRAC_W];
   assign last_smp = en ? (smp_q == '1) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         smp_q <= '0;
      end else if (clr || !en) begin
         acc_q <= '0;
         smp_q <= '0;
      end else if (period_end) begin
         acc_q <= sum[FRAC_W-1:0];
         smp_q <= smp_q + 1'b1;
      end
   end
endmodule

// File: rtl/fbg_pattern.sv
module fbg_pattern #(
   parameter int PAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bit_end,
   input  logic [PAT_W-1:0] pattern,
   output logic             pat_bit
);
   localparam int IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_W - 1);

   logic [IDX_W-1:0] idx_q;

   assign pat_bit = pattern[idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (clr)
         idx_q <= '0;
      else if (bit_end)
         idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
   end
endmodule

// File: rtl/fbg_counter.sv
module fbg_counter #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [PRE_W-1:0] prescale,
   input  logic [1:0]       extra,
   output logic             period_end
);
   localparam int CNT_W = PRE_W + 2;

   logic [PRE_W-1:0] div_eff;
   logic [CNT_W-1:0] len;
   logic [CNT_W-1:0] cnt_q;

   assign div_eff    = (prescale == '0) ? PRE_W'(1) : prescale;
   assign len        = CNT_W'(div_eff) + CNT_W'(extra);
   assign period_end = (cnt_q == len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || period_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
   parameter int PRE_W  = 16,
   parameter int FRAC_W = 4,
   parameter int PAT_W  = 8,
   parameter bit HAS_OS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_hold,
   input  logic              cfg_os_en,
   input  logic [PRE_W-1:0]  cfg_prescale,
   input  logic [FRAC_W-1:0] cfg_frac1,
   input  logic [PAT_W-1:0]  cfg_frac2,
   output logic              bit_tick,
   output logic              sample_tick
);
   import fbg_pkg::*;

   if (PRE_W < 2)  begin : g_bad_pre  $error("PRE_W must be at least 2");  end
   if (FRAC_W < 1) begin : g_bad_frac $error("FRAC_W must be at least 1"); end
   if (PAT_W < 1)  begin : g_bad_pat  $error("PAT_W must be at least 1");  end

   logic  os_active;
   logic  stretch;
   logic  last_smp;
   logic  pat_bit;
   logic  period_end;
   logic  [1:0] extra;
   tick_t tick_d, tick_q;

   if (HAS_OS) begin : g_os
      assign os_active = cfg_os_en;
      fbg_spread #(.FRAC_W(FRAC_W)) u_spread (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr        (cfg_hold),
         .en         (os_active),
         .frac       (cfg_frac1),
         .period_end (period_end),
         .stretch    (stretch),
         .last_smp   (last_smp)
      );
   end else begin : g_no_os
      assign os_active = 1'b0;
      assign stretch   = 1'b0;
      assign last_smp  = 1'b1;
   end

   fbg_pattern #(.PAT_W(PAT_W)) u_pattern (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cfg_hold),
      .bit_end (tick_d.bit_end),
      .pattern (cfg_frac2),
      .pat_bit (pat_bit)
   );

   assign extra = {1'b0, stretch} + {1'b0, last_smp & pat_bit};

   fbg_counter #(.PRE_W(PRE_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cfg_hold),
      .prescale   (cfg_prescale),
      .extra      (extra),
      .period_end (period_end)
   );

   assign tick_d.bit_end = period_end & last_smp & ~cfg_hold;
   assign tick_d.smp_end = period_end & os_active & ~cfg_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick_q <= '0;
      else
         tick_q <= tick_d;
   end

   assign bit_tick    = tick_q.bit_end;
   assign sample_tick = tick_q.smp_end;
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
   parameter int PRE_W  = 16,
   parameter int FRAC_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_hold,
   input logic              cfg_os_en,
   input logic [PRE_W-1:0]  cfg_prescale,
   input logic [FRAC_W-1:0] cfg_frac1,
   input logic              bit_tick,
   input logic              sample_tick
);
   localparam int GAP_W = PRE_W + FRAC_W + 4;

   logic [GAP_W-1:0] gap_q;
   logic [GAP_W-1:0] div_eff;
   logic [GAP_W-1:0] lo_len;
   logic [GAP_W-1:0] hi_len;

   assign div_eff = (cfg_prescale == '0) ? GAP_W'(1) : GAP_W'(cfg_prescale);
   assign lo_len  = cfg_os_en ? (div_eff << FRAC_W) : div_eff;
   assign hi_len  = lo_len + (cfg_os_en ? GAP_W'(cfg_frac1) : '0) + GAP_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= '0;
      else if (cfg_hold)
         gap_q <= '0;
      else if (bit_tick)
         gap_q <= GAP_W'(1);
      else
         gap_q <= gap_q + 1'b1;
   end

   assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hold |=> (!bit_tick && !sample_tick));

   assert_no_sample_R8: assert property (@(posedge clk) disable iff (!rst_n || cfg_hold)
      !cfg_os_en |-> !sample_tick);

   assert_bit_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n || cfg_hold)
      (cfg_os_en && bit_tick) |-> sample_tick);

   assert_bit_len_R1: assert property (@(posedge clk) disable iff (!rst_n || cfg_hold)
      bit_tick |-> (gap_q >= lo_len && gap_q <= hi_len));

   assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n || cfg_hold)
      (bit_tick && lo_len > GAP_W'(1)) |=> !bit_tick);
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.PRE_W(PRE_W), .FRAC_W(FRAC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_hold     (cfg_hold),
   .cfg_os_en    (cfg_os_en),
   .cfg_prescale (cfg_prescale),
   .cfg_frac1    (cfg_frac1),
   .bit_tick     (bit_tick),
   .sample_tick  (sample_tick)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_hold = 1'b1;
   logic        cfg_os_en = 1'b0;
   logic [15:0] cfg_prescale = '0;
   logic [3:0]  cfg_frac1 = '0;
   logic [7:0]  cfg_frac2 = '0;
   logic        bit_tick;
   logic        sample_tick;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   frac_baud_gen u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_os_en(cfg_os_en),
      .cfg_prescale(cfg_prescale), .cfg_frac1(cfg_frac1), .cfg_frac2(cfg_frac2),
      .bit_tick(bit_tick), .sample_tick(sample_tick)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_cfg(input int pre, input bit os, input int f, input int pat);
      int p1, base, exp_total, gap, sgap, bits, smps, total, bad_bit, bad_smp, bad_pulse;
      int exp_len;
      bit prev_bit;
      p1   = (pre == 0) ? 1 : pre;
      base = os ? 16 * p1 + f : p1;
      @(negedge clk);
      cfg_hold = 1'b1; cfg_prescale = 16'(pre); cfg_os_en = os;
      cfg_frac1 = 4'(f); cfg_frac2 = 8'(pat);
      repeat (3) @(negedge clk);
      check(!bit_tick && !sample_tick, "R7", "ticks during hold", {bit_tick, sample_tick}, 0);
      // run partway, freeze mid-bit, then restart
      cfg_hold = 1'b0;
      repeat (37 + 3 * p1) @(negedge clk);
      cfg_hold = 1'b1;
      @(negedge clk);
      check(!bit_tick && !sample_tick, "R7", "ticks after hold asserted", {bit_tick, sample_tick}, 0);
      repeat (2) @(negedge clk);
      cfg_hold = 1'b0;
      gap = 0; sgap = 0; bits = 0; smps = 0; total = 0;
      bad_bit = 0; bad_smp = 0; bad_pulse = 0; prev_bit = 1'b0;
      while (bits < 256 && !done) begin
         @(negedge clk);
         gap++; sgap++; total++;
         if (sample_tick) begin
            int j;
            j = smps % 16;
            exp_len = p1 + ((j + 1) * f) / 16 - (j * f) / 16;
            if (j == 15) exp_len += (pat >> ((smps / 16) % 8)) & 1;
            if (sgap != exp_len) begin
               if (bad_smp == 0)
                  $display("FAIL R4 sample %0d: actual %0d expected %0d", smps, sgap, exp_len);
               bad_smp++;
            end
            smps++; sgap = 0;
         end
         if (bit_tick) begin
            exp_len = base + ((pat >> (bits % 8)) & 1);
            if (gap != exp_len) begin
               if (bad_bit == 0)
                  $display("FAIL R2 bit %0d: actual %0d expected %0d", bits, gap, exp_len);
               bad_bit++;
            end
            if (os && !sample_tick) bad_smp++;
            bits++; gap = 0;
         end
         if (bit_tick && prev_bit && base + ((pat >> (bits % 8)) & 1) > 1) bad_pulse++;
         prev_bit = bit_tick;
      end
      exp_total = 256 * base + 32 * $countones(8'(pat));
      check(bad_bit == 0, os ? "R5" : "R1", "bit periods wrong", bad_bit, 0);
      check(bad_smp == 0, os ? "R3" : "R8", "sample periods wrong", bad_smp, 0);
      check(smps == (os ? 4096 : 0), os ? "R3" : "R8", "sample tick count", smps, os ? 4096 : 0);
      check(total == exp_total, "R9", "cycles over 256 bits", total, exp_total);
      check(bad_pulse == 0, "R9", "pulse wider than one cycle", bad_pulse, 0);
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!bit_tick && !sample_tick, "R7", "reset state", {bit_tick, sample_tick}, 0);
      rst_n = 1'b1;
      run_cfg(4, 1'b0, 0, 8'h00);   // R1
      run_cfg(5, 1'b0, 0, 8'hAA);   // R1, R2
      run_cfg(3, 1'b0, 0, 8'h01);   // R2: only bit 0 stretched
      run_cfg(0, 1'b0, 0, 8'h00);   // R6: one clock per bit
      run_cfg(1, 1'b0, 0, 8'hFF);   // R6 boundary, every bit stretched
      run_cfg(1, 1'b1, 0, 8'h00);   // R3
      run_cfg(2, 1'b1, 5, 8'h55);   // R4, R5
      run_cfg(3, 1'b1, 15, 8'hFF);  // R4 maximum spread
      run_cfg(0, 1'b1, 8, 8'h80);   // R6 with oversampling
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule